// File: doc/BRIEF.md
# Three-Digit Decimal Adder-Subtractor

This block takes two unsigned three-digit packed BCD operands and, on a start strobe, either adds them or subtracts the second from the first. The result comes back as a three-digit BCD magnitude with a sign flag and an overflow flag. A valid pulse marks the cycle in which a new result appears.

The adder works one decimal digit at a time. Each digit adds two nibbles and the incoming carry. When the digit sum is above nine, the adder applies a plus-six correction and sends a carry to the next digit.

Subtraction replaces each digit of the subtrahend with its nines' complement and then adds. If the top digit carries out, the difference is positive. That carry is fed back into the lowest digit (end-around carry) to give the final magnitude. If there is no carry out, the difference is negative, and the magnitude is the nines' complement of the raw sum. Operands are assumed to hold legal BCD digits. The result is computed combinationally and captured in one register stage.

Top module: `bcd_addsub`

## Requirements
- R1: While rst_ni is low, mag_o, neg_o, ovf_o and valid_o are all 0.
- R2: With sub_i=0, a start produces mag_o equal to the decimal sum of the two operands modulo 1000, and neg_o=0.
- R3: With sub_i=0, ovf_o is 1 exactly when the decimal sum exceeds 999.
- R4: Each output nibble is a legal BCD digit (0..9), with decimal carries passing from the low digit (bits 3:0) to the high digit (bits 11:8), e.g. 099+001 gives 100.
- R5: With sub_i=1 and A greater than B, mag_o is A-B and neg_o=0; for example, 068 minus 024 gives 044.
- R6: With sub_i=1 and A less than B, mag_o is B-A and neg_o=1.
- R7: With sub_i=1 and A equal to B, mag_o is 000 and neg_o=0.
- R8: With sub_i=1, ovf_o is 0.
- R9: valid_o is 1 for exactly the one cycle after a cycle in which start_i is 1, and is 0 otherwise.
- R10: In cycles without start_i, mag_o, neg_o and ovf_o keep their values, whatever a_i, b_i and sub_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Operand A, three packed BCD digits |
| b_i | input | 12 | Operand B, three packed BCD digits |
| sub_i | input | 1 | 1 selects A minus B, 0 selects A plus B |
| start_i | input | 1 | Captures a new result on this clock |
| mag_o | output | 12 | Result magnitude, three packed BCD digits |
| neg_o | output | 1 | Result is negative |
| ovf_o | output | 1 | The sum did not fit in three digits |
| valid_o | output | 1 | A new result is present this cycle |

## Verification
The bench uses the default of three digits. At this width, the operand range 000..999 is small enough to reach every boundary that matters.

Directed cases cover the following:
- carries that ripple through every digit (099+001, 999+001);
- sums that overflow to exactly 000;
- differences at both extremes (000-999, 999-000);
- equal operands, which would give a negative zero without special handling.

Random operations with idle gaps cover the rest. During those gaps the inputs keep changing, so the hold behaviour is tested against live input traffic.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  function automatic bcd_digit_t digit_nines(bcd_digit_t d);
    return bcd_digit_t'(4'd9 - d);
  endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       cin_i,
  output bcd_digit_t sum_o,
  output logic       cout_o
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    raw    = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
    fixed  = raw + 5'd6;
    cout_o = raw > 5'd9;
    sum_o  = cout_o ? fixed[DIGIT_W-1:0] : raw[DIGIT_W-1:0];
  end

  always_comb begin
    p_digit_bcd_r4: assert (!(a_i <= 4'd9 && b_i <= 4'd9) || sum_o <= 4'd9);
  end
endmodule

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    bcd_digit_add u_digit (
      .a_i   (a_i[g*DIGIT_W +: DIGIT_W]),
      .b_i   (b_i[g*DIGIT_W +: DIGIT_W]),
      .cin_i (carry[g]),
      .sum_o (sum_o[g*DIGIT_W +: DIGIT_W]),
      .cout_o(carry[g+1])
    );
  end

  assign cout_o = carry[NUM_DIGITS];
endmodule

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] comp_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign comp_o[g*DIGIT_W +: DIGIT_W] = digit_nines(val_i[g*DIGIT_W +: DIGIT_W]);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         start_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o,
  output logic         ovf_o,
  output logic         valid_o
);
  logic [W-1:0] b_nines, b_eff;
  logic [W-1:0] raw_sum, raw_wrap, raw_nines;
  logic         raw_carry, wrap_carry;
  logic [W-1:0] mag_d;
  logic         neg_d, ovf_d;

  bcd_nines_comp #(.NUM_DIGITS(NUM_DIGITS)) u_comp_b (
    .val_i (b_i),
    .comp_o(b_nines)
  );

  assign b_eff = sub_i ? b_nines : b_i;

  bcd_ripple_add #(.NUM_DIGITS(NUM_DIGITS)) u_main_add (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (1'b0),
    .sum_o (raw_sum),
    .cout_o(raw_carry)
  );

  // end-around carry: second pass adds the top carry into the lowest digit
  bcd_ripple_add #(.NUM_DIGITS(NUM_DIGITS)) u_wrap_add (
    .a_i   (raw_sum),
    .b_i   ({W{1'b0}}),
    .cin_i (1'b1),
    .sum_o (raw_wrap),
    .cout_o(wrap_carry)
  );

  bcd_nines_comp #(.NUM_DIGITS(NUM_DIGITS)) u_comp_raw (
    .val_i (raw_sum),
    .comp_o(raw_nines)
  );

  always_comb begin
    if (!sub_i)         mag_d = raw_sum;
    else if (raw_carry) mag_d = raw_wrap;
    else                mag_d = raw_nines;
    // all-nines raw sum means equal operands: fold negative zero to +0
    neg_d = sub_i && !raw_carry && (raw_nines != '0);
    ovf_d = !sub_i && raw_carry;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o   <= '0;
      neg_o   <= 1'b0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        mag_o <= mag_d;
        neg_o <= neg_d;
        ovf_o <= ovf_d;
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable({mag_o, neg_o, ovf_o}));
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sub_i) |=> !ovf_o);
  p_add_positive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !sub_i) |=> !neg_o);
  p_equal_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sub_i && a_i == b_i) |=> (mag_o == '0 && !neg_o));
  p_wrap_fits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && raw_carry) |-> !wrap_carry);
  p_flags_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(neg_o && ovf_o));
endmodule

// File: tb/test_bcd_addsub.sv
module test_bcd_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         sub_i = 1'b0, start_i = 1'b0;
  logic [W-1:0] mag_o;
  logic         neg_o, ovf_o, valid_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_addsub i_bcd_addsub (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .start_i(start_i), .mag_o(mag_o), .neg_o(neg_o), .ovf_o(ovf_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(logic [W-1:0] x);
    return int'(x[11:8]) * 100 + int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int    e_mag = 0;
  bit    e_neg = 0, e_ovf = 0, e_valid = 0;
  string e_tag = "R10";
  string e_ovf_tag = "R10";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_mag = 0; e_neg = 0; e_ovf = 0; e_valid = 0;
      e_tag = "R10"; e_ovf_tag = "R10";
    end else begin
      e_valid = start_i;
      if (start_i) begin
        int a, b, s;
        a = from_bcd(a_i);
        b = from_bcd(b_i);
        if (!sub_i) begin
          s = a + b;
          e_mag = s % 1000; e_neg = 0; e_ovf = s > 999;
          e_tag = "R2 R4"; e_ovf_tag = "R3";
        end else begin
          s = a - b;
          e_mag = s < 0 ? -s : s; e_neg = s < 0; e_ovf = 0;
          e_tag = s > 0 ? "R5" : (s < 0 ? "R6" : "R7");
          e_ovf_tag = "R8";
        end
      end else begin
        e_tag = "R10"; e_ovf_tag = "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      check(valid_o == e_valid, "R9", "valid_o", int'(valid_o), int'(e_valid));
      check(from_bcd(mag_o) == e_mag && mag_o[3:0] <= 9 && mag_o[7:4] <= 9 && mag_o[11:8] <= 9,
            e_tag, "mag_o", from_bcd(mag_o), e_mag);
      check(neg_o == e_neg, e_tag, "neg_o", int'(neg_o), int'(e_neg));
      check(ovf_o == e_ovf, e_ovf_tag, "ovf_o", int'(ovf_o), int'(e_ovf));
    end
  end

  task automatic op(int a, int b, bit sub, int idle);
    @(negedge clk);
    a_i = to_bcd(a); b_i = to_bcd(b); sub_i = sub; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < idle; k++) begin
      a_i = to_bcd($urandom_range(999)); b_i = to_bcd($urandom_range(999));
      sub_i = 1'(($urandom() & 1));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    a_i = to_bcd(555); b_i = to_bcd(444); sub_i = 1'b1; start_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held clear during reset, even with start asserted
    check(mag_o == '0, "R1", "mag_o", from_bcd(mag_o), 0);
    check({neg_o, ovf_o, valid_o} == 3'b000, "R1", "flags", int'({neg_o, ovf_o, valid_o}), 0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    op(68, 24, 1, 1);    // R5 worked example
    op(24, 68, 1, 2);    // R6
    op(345, 345, 1, 1);  // R7
    op(0, 0, 1, 0);      // R7
    op(123, 456, 0, 1);  // R2
    op(9, 1, 0, 0);      // R4
    op(99, 1, 0, 1);     // R4
    op(999, 1, 0, 1);    // R3
    op(500, 500, 0, 0);  // R3
    op(999, 999, 0, 1);  // R3
    op(0, 999, 1, 1);    // R6 extreme
    op(999, 0, 1, 1);    // R5 extreme
    op(100, 1, 1, 3);    // R5 borrow chain
    op(1, 100, 1, 0);    // R6
    for (int i = 0; i < 400; i++)
      op($urandom_range(999), $urandom_range(999), 1'(($urandom() & 1)), $urandom_range(2));
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule